// File: doc/BRIEF.md
# USB Host Transaction Result Tracker

This block sits next to a USB host serial interface engine and follows one host transaction at a time. Software starts a transaction by writing a command byte, which holds the token PID in its upper nibble and the target endpoint in its lower nibble, together with an 8-bit maximum data length. From then on the block watches decoded events that the engine reports from the bus: a handshake PID, the end of a received data packet with its data PID and byte count, an error flag for CRC or PID check failures, and a marker that a device response has started.

The block counts full-speed bit times with a one-cycle bit strobe. If the device does not answer within 18 bit times, the transaction ends with a time-out. When the transaction ends for any reason, the block captures a status byte and raises a one-cycle done pulse. The status byte changes only at done, or when a new command clears it, so software reads a frozen result and never a live view of the bus. The block also tells the engine when a zero-length data packet is to be sent.

Top module: `usb_xact_tracker`

## Requirements
- R1: A cycle with `cmdWr` high stores `cmdByte[7:4]` on `curPid` and `cmdByte[3:0]` on `curEp`, latches `maxLen`, clears `status` to 0 and opens a transaction. Bus events in that same cycle are ignored.
- R2: `done` is high for exactly one cycle, in the cycle after the event that ends an open transaction. Each transaction ends once.
- R3: A handshake (`hsValid`) ends the transaction. `hsPid` 0010 (ACK) sets status bit 0, 1010 (NAK) sets bit 6 and 1110 (STALL) sets bit 7.
- R4: A received data packet (`dataValid`) ends the transaction. Status bit 3 is 1 for `dataPid` 1011 (DATA1) and 0 for 0011 (DATA0). Bit 0 is set when the packet has no error and no overflow.
- R5: Status bit 5 (overflow) is set when `rxCount` is greater than the latched maximum length.
- R6: Status bit 1 (error) is set when `errFlag` is high together with the ending event.
- R7: If 18 `bitStb` pulses arrive after the start with no response, the transaction ends with `status` = 0x04 (bit 2, time-out alone).
- R8: `respStart` stops the time-out count. Later strobes never cause a time-out, and the following handshake or data event still ends the transaction.
- R9: Between done and the next command, `status` keeps its value and bus events cause no done. After reset, `status` is 0 and `done` is 0.
- R10: Status bit 4 always reads 0 in host operation.
- R11: `txZeroLen` is 1 while a transaction is open whose PID is OUT (0001) or SETUP (1101) and whose latched length is 0. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWr | input | 1 | Command write strobe, starts a transaction |
| cmdByte | input | 8 | PID in [7:4], endpoint in [3:0] |
| maxLen | input | 8 | Maximum data length, latched at command write |
| bitStb | input | 1 | One-cycle pulse per full-speed bit time |
| respStart | input | 1 | Device response has begun |
| hsValid | input | 1 | Handshake packet received |
| hsPid | input | 4 | Handshake PID nibble |
| dataValid | input | 1 | Data packet received completely |
| dataPid | input | 4 | Data PID nibble |
| rxCount | input | 8 | Bytes received in the data packet |
| errFlag | input | 1 | CRC5, CRC16 or PID check failure |
| done | output | 1 | One-cycle transaction-end pulse |
| status | output | 8 | Frozen result byte |
| curPid | output | 4 | PID of the current command |
| curEp | output | 4 | Endpoint of the current command |
| txZeroLen | output | 1 | Send a zero-length data packet |

## Verification
The hardest case to reach is a race near the time-out limit: the 18th bit strobe alone, a response marker that stops the count a few strobes before the limit, and a command write in the same cycle as a bus event. The bench makes these cases happen by spacing strobes with counted loops, so it can stop one strobe short of the limit, check that no done appears, and then give the final strobe. It also sends events while no transaction is open and together with a command write. A behavioural model built from the requirements is compared with all outputs on every clock.

// File: rtl/usb_trk_pkg.sv
package usb_trk_pkg;
  localparam logic [3:0] PID_OUT   = 4'h1;
  localparam logic [3:0] PID_ACK   = 4'h2;
  localparam logic [3:0] PID_DATA1 = 4'hB;
  localparam logic [3:0] PID_NAK   = 4'hA;
  localparam logic [3:0] PID_SETUP = 4'hD;
  localparam logic [3:0] PID_STALL = 4'hE;

  // status bit positions decoded by software
  localparam int ST_ACK   = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_TOUT  = 2;
  localparam int ST_SEQ   = 3;
  localparam int ST_SETUP = 4;
  localparam int ST_OVF   = 5;
  localparam int ST_NAK   = 6;
  localparam int ST_STALL = 7;

  typedef struct packed {
    logic start;      // command accepted
    logic finishEvt;  // ended by a bus event
    logic finishTo;   // ended by time-out
  } trkStrobe_t;
endpackage

// File: rtl/usb_trk_ctrl.sv
module usb_trk_ctrl
  import usb_trk_pkg::*;
#(
  parameter int TIMEOUT_BITS = 18
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       bitStb,
  input  logic       respStart,
  input  logic       hsValid,
  input  logic       dataValid,
  output trkStrobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_BITS - 1);

  logic             busyQ;
  logic             respSeenQ;
  logic [CNT_W-1:0] bitCnt;
  logic             doneQ;
  logic             anyEvt;
  logic             timing;

  assign anyEvt = hsValid | dataValid;
  assign timing = busyQ & ~cmdWr & ~respSeenQ & ~respStart & ~anyEvt;

  always_comb begin
    stb.start     = cmdWr;
    stb.finishEvt = busyQ & ~cmdWr & anyEvt;
    stb.finishTo  = timing & bitStb & (bitCnt == LAST_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      respSeenQ <= 1'b0;
      bitCnt    <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= stb.finishEvt | stb.finishTo;
      if (stb.start) begin
        busyQ     <= 1'b1;
        respSeenQ <= 1'b0;
        bitCnt    <= '0;
      end else if (stb.finishEvt || stb.finishTo) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        if (respStart) respSeenQ <= 1'b1;
        if (timing && bitStb) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2
  AST_DONE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busyQ)); // R2
  AST_TIMER_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (respSeenQ && !cmdWr) |=> $stable(bitCnt)); // R8
endmodule

// File: rtl/usb_trk_datapath.sv
module usb_trk_datapath
  import usb_trk_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  trkStrobe_t       stb,
  input  logic             busy,
  input  logic [7:0]       cmdByte,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             hsValid,
  input  logic [3:0]       hsPid,
  input  logic             dataValid,
  input  logic [3:0]       dataPid,
  input  logic [LEN_W-1:0] rxCount,
  input  logic             errFlag,
  output logic [3:0]       curPid,
  output logic [3:0]       curEp,
  output logic [7:0]       status,
  output logic             txZeroLen
);
  logic [3:0]       pidQ;
  logic [3:0]       epQ;
  logic [LEN_W-1:0] lenQ;
  logic [7:0]       statusQ;
  logic [7:0]       evtStatus;
  logic             overflow;

  assign overflow = dataValid & (rxCount > lenQ);

  always_comb begin
    evtStatus           = '0;
    evtStatus[ST_STALL] = hsValid & (hsPid == PID_STALL);
    evtStatus[ST_NAK]   = hsValid & (hsPid == PID_NAK);
    evtStatus[ST_OVF]   = overflow;
    evtStatus[ST_SEQ]   = dataValid & (dataPid == PID_DATA1);
    evtStatus[ST_ERR]   = errFlag;
    evtStatus[ST_ACK]   = (hsValid & (hsPid == PID_ACK))
                        | (dataValid & ~errFlag & ~overflow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pidQ    <= '0;
      epQ     <= '0;
      lenQ    <= '0;
      statusQ <= '0;
    end else if (stb.start) begin
      pidQ    <= cmdByte[7:4];
      epQ     <= cmdByte[3:0];
      lenQ    <= maxLen;
      statusQ <= '0;
    end else if (stb.finishEvt) begin
      statusQ <= evtStatus;
    end else if (stb.finishTo) begin
      statusQ <= 8'(1 << ST_TOUT);
    end
  end

  assign curPid    = pidQ;
  assign curEp     = epQ;
  assign status    = statusQ;
  assign txZeroLen = busy & (lenQ == '0) & ((pidQ == PID_OUT) | (pidQ == PID_SETUP));

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (status == 8'h00)); // R1
  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.start && !stb.finishEvt && !stb.finishTo) |=> $stable(status)); // R9
  AST_TIMEOUT_ALONE: assert property (@(posedge clk) disable iff (!rstN)
    status[ST_TOUT] |-> ((status & 8'hFB) == 8'h00)); // R7
  AST_SETUP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !status[ST_SETUP]); // R10
endmodule

// File: rtl/usb_xact_tracker.sv
module usb_xact_tracker
  import usb_trk_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int TIMEOUT_BITS = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWr,
  input  logic [7:0]       cmdByte,
  input  logic [LEN_W-1:0] maxLen,
  input  logic             bitStb,
  input  logic             respStart,
  input  logic             hsValid,
  input  logic [3:0]       hsPid,
  input  logic             dataValid,
  input  logic [3:0]       dataPid,
  input  logic [LEN_W-1:0] rxCount,
  input  logic             errFlag,
  output logic             done,
  output logic [7:0]       status,
  output logic [3:0]       curPid,
  output logic [3:0]       curEp,
  output logic             txZeroLen
);
  trkStrobe_t stb;
  logic       busy;

  usb_trk_ctrl #(.TIMEOUT_BITS(TIMEOUT_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .bitStb(bitStb),
    .respStart(respStart), .hsValid(hsValid), .dataValid(dataValid),
    .stb(stb), .busy(busy), .done(done)
  );

  usb_trk_datapath #(.LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy),
    .cmdByte(cmdByte), .maxLen(maxLen),
    .hsValid(hsValid), .hsPid(hsPid),
    .dataValid(dataValid), .dataPid(dataPid),
    .rxCount(rxCount), .errFlag(errFlag),
    .curPid(curPid), .curEp(curEp), .status(status), .txZeroLen(txZeroLen)
  );
endmodule

// File: tb/usb_xact_tracker_bench.sv
`timescale 1ns/1ps
module usb_xact_tracker_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdWr = 1'b0;
  logic [7:0] cmdByte = '0;
  logic [7:0] maxLen = '0;
  logic       bitStb = 1'b0;
  logic       respStart = 1'b0;
  logic       hsValid = 1'b0;
  logic [3:0] hsPid = '0;
  logic       dataValid = 1'b0;
  logic [3:0] dataPid = '0;
  logic [7:0] rxCount = '0;
  logic       errFlag = 1'b0;
  logic       done;
  logic [7:0] status;
  logic [3:0] curPid;
  logic [3:0] curEp;
  logic       txZeroLen;

  int checks = 0;
  int errors = 0;
  string curReq = "R9";

  always #2.5 clk = ~clk;

  usb_xact_tracker u_usb_xact_tracker (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdByte(cmdByte), .maxLen(maxLen),
    .bitStb(bitStb), .respStart(respStart), .hsValid(hsValid), .hsPid(hsPid),
    .dataValid(dataValid), .dataPid(dataPid), .rxCount(rxCount), .errFlag(errFlag),
    .done(done), .status(status), .curPid(curPid), .curEp(curEp), .txZeroLen(txZeroLen)
  );

  // behavioural reference model
  int   mPid = 0, mEp = 0, mLen = 0, mBits = 0;
  int   mStatus = 0;
  bit   mBusy = 0, mResp = 0, mDone = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPid = 0; mEp = 0; mLen = 0; mBits = 0; mStatus = 0;
      mBusy = 0; mResp = 0; mDone = 0;
    end else begin
      mDone = 0;
      if (cmdWr) begin
        mPid = cmdByte / 16; mEp = cmdByte % 16; mLen = maxLen;
        mStatus = 0; mBusy = 1; mResp = 0; mBits = 0;
      end else if (mBusy) begin
        if (hsValid || dataValid) begin
          int s;
          bit ovf;
          s = 0;
          ovf = dataValid && (int'(rxCount) > mLen);
          if (hsValid && hsPid == 4'h2) s += 1;
          if (hsValid && hsPid == 4'hA) s += 64;
          if (hsValid && hsPid == 4'hE) s += 128;
          if (dataValid && dataPid == 4'hB) s += 8;
          if (ovf) s += 32;
          if (errFlag) s += 2;
          if (dataValid && !errFlag && !ovf && !(hsValid && hsPid == 4'h2)) s += 1;
          mStatus = s; mDone = 1; mBusy = 0;
        end else if (respStart) begin
          mResp = 1;
        end else if (!mResp && bitStb) begin
          mBits++;
          if (mBits == 18) begin
            mStatus = 4; mDone = 1; mBusy = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    bit zl;
    zl = mBusy && mLen == 0 && (mPid == 1 || mPid == 13);
    checks++;
    if (status !== 8'(mStatus) || done !== mDone || curPid !== 4'(mPid) ||
        curEp !== 4'(mEp) || txZeroLen !== zl) begin
      errors++;
      $display("FAIL %s model: status=%h/%h done=%b/%b pid=%h/%h ep=%h/%h zl=%b/%b",
               curReq, status, 8'(mStatus), done, mDone, curPid, 4'(mPid),
               curEp, 4'(mEp), txZeroLen, zl);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cmd(logic [7:0] c, logic [7:0] l);
    cmdWr = 1'b1; cmdByte = c; maxLen = l;
    tick();
    cmdWr = 1'b0;
  endtask

  task automatic hs(logic [3:0] p, logic e);
    hsValid = 1'b1; hsPid = p; errFlag = e;
    tick();
    hsValid = 1'b0; errFlag = 1'b0;
  endtask

  task automatic dat(logic [3:0] p, logic [7:0] n, logic e);
    dataValid = 1'b1; dataPid = p; rxCount = n; errFlag = e;
    tick();
    dataValid = 1'b0; errFlag = 1'b0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      bitStb = 1'b1; tick(); bitStb = 1'b0; tick(); tick();
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    curReq = "R9";
    chk("R9", "reset status", status, 8'h00);
    chk("R9", "reset done", done, 0);

    curReq = "R1";
    cmd(8'h95, 8'd8);
    chk("R1", "pid", curPid, 4'h9);
    chk("R1", "endpoint", curEp, 4'h5);
    chk("R1", "status cleared", status, 8'h00);
    tick(); tick();

    curReq = "R4";
    dat(4'hB, 8'd8, 1'b0);
    chk("R2", "done pulse", done, 1);
    chk("R4", "DATA1 good", status, 8'h09);
    tick();
    chk("R2", "done one cycle", done, 0);

    curReq = "R5";
    cmd(8'h93, 8'd8);
    dat(4'h3, 8'd9, 1'b0);
    chk("R5", "overflow", status, 8'h20);
    cmd(8'h93, 8'd8);
    dat(4'h3, 8'd0, 1'b0);
    chk("R4", "DATA0 good", status, 8'h01);

    curReq = "R3";
    cmd(8'h12, 8'd4);
    hs(4'h2, 1'b0);
    chk("R3", "ACK", status, 8'h01);
    cmd(8'h12, 8'd4);
    hs(4'hA, 1'b0);
    chk("R3", "NAK", status, 8'h40);
    cmd(8'h12, 8'd4);
    hs(4'hE, 1'b0);
    chk("R3", "STALL", status, 8'h80);

    curReq = "R6";
    cmd(8'h97, 8'd16);
    dat(4'h3, 8'd4, 1'b1);
    chk("R6", "error", status, 8'h02);

    curReq = "R7";
    cmd(8'h9F, 8'd64);
    strobes(17);
    chk("R7", "no done at 17", status, 8'h00);
    bitStb = 1'b1; tick(); bitStb = 1'b0;
    chk("R7", "timeout done", done, 1);
    chk("R7", "timeout status", status, 8'h04);
    tick();

    curReq = "R8";
    cmd(8'h91, 8'd8);
    strobes(15);
    respStart = 1'b1; tick(); respStart = 1'b0;
    strobes(30);
    chk("R8", "no timeout after response", status, 8'h00);
    hs(4'hA, 1'b0);
    chk("R8", "later NAK ends", status, 8'h40);

    curReq = "R9";
    tick();
    hs(4'hE, 1'b0);
    chk("R9", "idle event no done", done, 0);
    chk("R9", "status frozen", status, 8'h40);
    strobes(20);
    chk("R9", "still frozen", status, 8'h40);

    curReq = "R1";
    cmdWr = 1'b1; cmdByte = 8'h93; maxLen = 8'd8; hsValid = 1'b1; hsPid = 4'h2;
    tick();
    cmdWr = 1'b0; hsValid = 1'b0;
    chk("R1", "event with cmd ignored", done, 0);
    chk("R1", "status after cmd", status, 8'h00);
    hs(4'h2, 1'b0);
    chk("R1", "next event accepted", status, 8'h01);

    curReq = "R11";
    cmd(8'h13, 8'd0);
    chk("R11", "OUT zero length", txZeroLen, 1);
    hs(4'h2, 1'b0);
    chk("R11", "cleared at end", txZeroLen, 0);
    cmd(8'hD0, 8'd0);
    chk("R11", "SETUP zero length", txZeroLen, 1);
    cmd(8'h90, 8'd0);
    chk("R11", "IN not zero length", txZeroLen, 0);
    cmd(8'h13, 8'd1);
    chk("R11", "OUT nonzero length", txZeroLen, 0);

    curReq = "R10";
    dat(4'hB, 8'd0, 1'b0);
    chk("R10", "setup bit low", int'(status[4]), 0);
    tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule